// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into an asynchronous serial bit stream. A holding register sits in front of the shift register. A byte written while the shifter is idle moves into the shifter on the next cycle. The holding register is then free, so the host can supply the next byte while the current frame is still going out. That next byte starts the moment the current frame's last stop tick ends, with no idle gap between the frames.

The frame format is chosen at run time. The settings are data length (5 to 8 bits), stop length (1, 1.5 or 2 bits), five parity modes and a forced break. Bit timing comes from a one-cycle enable that pulses at 16 times the bit rate. The shifter captures the format when it loads a byte. A change to the settings therefore affects only frames that start after the change. Two registered flags report status: one says the holding register is empty, the other says the whole transmitter has gone quiet.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After synchronous reset, `txd` is 1, `hold_empty` is 1 and `shift_empty` is 1.
- R2: A write (`wr_en` high at a clock edge) makes `hold_empty` 0 after that edge. If the shifter is idle, the byte moves to the shifter at the next edge, and `hold_empty` returns to 1 while the frame is being sent.
- R3: `shift_empty` is 1 only when the holding register is empty and no frame is in progress. It drops to 0 right after the edge that takes a write.
- R4: The line idles at 1. A frame is one start bit of 0, then the data bits least significant bit first. Each bit lasts 16 tick pulses. The number of data bits comes from `cfg_wlen`: 00=5, 01=6, 10=7, 11=8.
- R5: `cfg_stop2`=0 gives one stop bit of 1 (16 ticks). `cfg_stop2`=1 gives 1.5 stop bits (24 ticks) for 5-bit data and 2 stop bits (32 ticks) for 6, 7 or 8-bit data.
- R6: With `cfg_par_en`=1, a parity bit follows the last data bit. Its value depends on `cfg_par_stick` and `cfg_par_even`:
  - `cfg_par_stick`=0 and `cfg_par_even`=1: the bit is the XOR of the sent data bits (even parity).
  - `cfg_par_stick`=0 and `cfg_par_even`=0: the bit is the inverse of that XOR (odd parity).
  - `cfg_par_stick`=1: the bit is the inverse of `cfg_par_even` (mark or space).
  - With `cfg_par_en`=0, no parity bit is sent.
- R7: While `cfg_brk` is 1, `txd` is 0 from the edge after it rises. Frame sequencing and the flags carry on unchanged.
- R8: A byte written while a frame is in progress starts its start bit immediately after the last stop tick of that frame. The next frame's start bit follows the stop bit(s) with no idle time.
- R9: A write while the holding register is already full overwrites the held byte. Only the latest byte is sent.
- R10: The format in force when a byte enters the shifter applies to the whole of that frame. Later changes to the `cfg_*` inputs do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe into the holding register |
| wr_data | input | 8 | Byte to send |
| cfg_wlen | input | 2 | Data length code (00=5 … 11=8) |
| cfg_stop2 | input | 1 | Long stop select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | Even parity select / stick value select |
| cfg_par_stick | input | 1 | Stick parity |
| cfg_brk | input | 1 | Force line to 0 |
| tick16 | input | 1 | Enable pulse at 16x bit rate |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register empty |
| shift_empty | output | 1 | Holding and shift registers empty, line idle |

## Verification
The flags respond to a write on a fixed schedule:
- `hold_empty` and `shift_empty` fall one edge after the write.
- When the shifter is idle, `hold_empty` rises again one edge later.
- The start bit appears on `txd` one edge after that.

The bench samples the ports on the falling clock edge, once per edge in that sequence. Serial content is checked by a bench-side receiver. It counts tick pulses from each falling edge of the line and samples in the middle of each bit, 8 + 16·k ticks after the fall. For back-to-back frames, the tick count between two start edges is compared with the expected frame length, within one tick. This comparison separates 1, 1.5 and 2 stop bits and proves there is no idle gap. Break is checked one edge after `cfg_brk` changes.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } stx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop2;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } stx_fmt_t;

endpackage

// File: rtl/stx_hold.sv
module stx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic              full_next,
  output logic [DATA_W-1:0] data
);

  // a write wins over a take in the same cycle: the shifter gets the old byte
  always_comb full_next = wr_en | (full & ~take);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_next;
      if (wr_en) data <= wr_data;
    end
  end

endmodule

// File: rtl/stx_shift.sv
module stx_shift
  import stx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  stx_fmt_t          fmt_in,
  output logic              take,
  output logic              busy_next,
  output logic              line_bit
);

  localparam int MIN_W  = DATA_W - 3;
  localparam int CNT_W  = $clog2(2 * OVS);
  localparam int BIT_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_1   = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] LAST_1P5 = CNT_W'(OVS + OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_2   = CNT_W'(2 * OVS - 1);

  stx_state_e        state, state_d;
  stx_fmt_t          fmt_q;
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  tcnt;
  logic [BIT_W-1:0]  bits_left;
  logic              par_q;

  logic [BIT_W-1:0]  ld_len;
  logic [DATA_W-1:0] ld_mask;
  logic [DATA_W-1:0] ld_bits;
  logic              ld_xor;
  logic              ld_par;
  logic [CNT_W-1:0]  stop_last;
  logic              bit_end;
  logic              stop_end;

  // data length of the byte about to be loaded, and its bit mask
  always_comb ld_len = BIT_W'(MIN_W) + BIT_W'(fmt_in.wlen);

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign ld_mask[i] = (BIT_W'(i) < ld_len);
    end
  endgenerate

  always_comb begin
    ld_bits = hold_data & ld_mask;
    ld_xor  = ^ld_bits;
    if (fmt_in.par_stick) ld_par = ~fmt_in.par_even;
    else if (fmt_in.par_even) ld_par = ld_xor;
    else ld_par = ~ld_xor;
  end

  // stop length from the format captured at load
  always_comb begin
    if (!fmt_q.stop2) stop_last = LAST_1;
    else if (fmt_q.wlen == 2'b00) stop_last = LAST_1P5;
    else stop_last = LAST_2;
  end

  always_comb begin
    bit_end  = tick && (tcnt == LAST_1);
    stop_end = tick && (state == ST_STOP) && (tcnt == stop_last);
    take     = hold_full && ((state == ST_IDLE) || stop_end);
  end

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (take) state_d = ST_START;
      ST_START: if (bit_end) state_d = ST_DATA;
      ST_DATA:  if (bit_end && bits_left == BIT_W'(1))
                  state_d = fmt_q.par_en ? ST_PAR : ST_STOP;
      ST_PAR:   if (bit_end) state_d = ST_STOP;
      ST_STOP:  if (stop_end) state_d = take ? ST_START : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb busy_next = (state_d != ST_IDLE);

  always_comb begin
    unique case (state)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = sr[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      fmt_q     <= '0;
      sr        <= '0;
      tcnt      <= '0;
      bits_left <= '0;
      par_q     <= 1'b0;
    end else begin
      state <= state_d;
      if (take) begin
        fmt_q     <= fmt_in;
        sr        <= ld_bits;
        bits_left <= ld_len;
        par_q     <= ld_par;
        tcnt      <= '0;
      end else if (state != ST_IDLE && tick) begin
        if (state == ST_STOP) begin
          tcnt <= stop_end ? '0 : tcnt + 1'b1;
        end else begin
          tcnt <= bit_end ? '0 : tcnt + 1'b1;
        end
        if (state == ST_DATA && bit_end) begin
          sr        <= sr >> 1;
          bits_left <= bits_left - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/stx_line_out.sv
module stx_line_out (
  input  logic clk,
  input  logic rst,
  input  logic line_bit,
  input  logic brk,
  input  logic full_next,
  input  logic busy_next,
  output logic txd,
  output logic hold_empty,
  output logic shift_empty
);

  always_ff @(posedge clk) begin
    if (rst) begin
      txd         <= 1'b1;
      hold_empty  <= 1'b1;
      shift_empty <= 1'b1;
    end else begin
      txd         <= brk ? 1'b0 : line_bit;
      hold_empty  <= ~full_next;
      shift_empty <= ~full_next & ~busy_next;
    end
  end

endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf
  import stx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_stop2,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              cfg_brk,
  input  logic              tick16,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty
);

  stx_fmt_t          fmt;
  logic              take;
  logic              h_full;
  logic              h_full_next;
  logic [DATA_W-1:0] h_data;
  logic              busy_next;
  logic              line_bit;

  always_comb begin
    fmt.wlen      = cfg_wlen;
    fmt.stop2     = cfg_stop2;
    fmt.par_en    = cfg_par_en;
    fmt.par_even  = cfg_par_even;
    fmt.par_stick = cfg_par_stick;
  end

  stx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (take),
    .full      (h_full),
    .full_next (h_full_next),
    .data      (h_data)
  );

  stx_shift #(.DATA_W(DATA_W), .OVS(OVS)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick16),
    .hold_full (h_full),
    .hold_data (h_data),
    .fmt_in    (fmt),
    .take      (take),
    .busy_next (busy_next),
    .line_bit  (line_bit)
  );

  stx_line_out i_out (
    .clk         (clk),
    .rst         (rst),
    .line_bit    (line_bit),
    .brk         (cfg_brk),
    .full_next   (h_full_next),
    .busy_next   (busy_next),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty)
  );

endmodule

// File: rtl/stx_checker.sv
module stx_checker (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic cfg_brk,
  input logic txd,
  input logic hold_empty,
  input logic shift_empty
);

  // R7: break drives the line to space one edge later
  a_r7_break_space: assert property (@(posedge clk) disable iff (rst)
    cfg_brk |=> !txd);

  // R3: quiet transmitter implies an empty holding register
  a_r3_shift_implies_hold: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> hold_empty);

  // R2: a write fills the holding register
  a_r2_write_fills: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !hold_empty);

  // R2: holding register drains only into a busy shifter
  a_r2_take_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_empty) |-> !shift_empty);

  // R4: idle line sits at mark unless break was requested
  a_r4_idle_mark: assert property (@(posedge clk) disable iff (rst)
    (shift_empty && !$past(cfg_brk)) |-> txd);

endmodule

bind ser_tx_dbuf stx_checker i_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .cfg_brk     (cfg_brk),
  .txd         (txd),
  .hold_empty  (hold_empty),
  .shift_empty (shift_empty)
);

// File: tb/test_ser_tx_dbuf.sv
`timescale 1ns/1ps
module test_ser_tx_dbuf;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] cfg_wlen = 2'b11;
  logic       cfg_stop2 = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_par_stick = 1'b0;
  logic       cfg_brk = 1'b0;
  logic       tick16 = 1'b0;
  logic       txd, hold_empty, shift_empty;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [1:0] tdiv = 2'd0;

  ser_tx_dbuf i_ser_tx_dbuf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_wlen(cfg_wlen), .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_par_stick(cfg_par_stick),
    .cfg_brk(cfg_brk), .tick16(tick16), .txd(txd),
    .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      tdiv   <= 2'd0;
      tick16 <= 1'b0;
    end else begin
      tdiv   <= tdiv + 2'd1;
      tick16 <= (tdiv == 2'd3);
    end
  end

  // expected frames
  logic [7:0] e_data [64];
  int         e_n    [64];
  int         e_par  [64];
  int         e_len  [64];
  bit         e_b2b  [64];
  int         e_wr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int par_of(input logic [7:0] d, input int n,
                                input bit en, input bit ev, input bit st);
    logic x;
    x = 1'b0;
    for (int i = 0; i < n; i++) x = x ^ d[i];
    if (!en) return -1;
    if (st) return ev ? 0 : 1;
    return ev ? int'(x) : int'(~x);
  endfunction

  task automatic push(input logic [7:0] d, input bit b2b);
    int n, p, stp;
    n   = 5 + int'(cfg_wlen);
    p   = par_of(d, n, cfg_par_en, cfg_par_even, cfg_par_stick);
    stp = !cfg_stop2 ? 16 : (n == 5 ? 24 : 32);
    e_data[e_wr] = d;
    e_n[e_wr]    = n;
    e_par[e_wr]  = p;
    e_len[e_wr]  = 16 * (1 + n + (p >= 0 ? 1 : 0)) + stp;
    e_b2b[e_wr]  = b2b;
    e_wr++;
  endtask

  // bench receiver: samples mid-bit by tick count
  bit         mon_en = 1'b1;
  bit         m_act = 1'b0;
  logic       m_prev = 1'b1;
  int         m_t, m_k, m_since = 0;
  int         m_idx = 0;
  logic [7:0] m_data;
  logic       m_par;

  always @(negedge clk) begin
    if (!rst && mon_en) begin
      if (tick16) m_since++;
      if (!m_act) begin
        if (m_prev && !txd) begin
          if (m_idx >= e_wr) begin
            chk(1'b0, "R9 unexpected frame", m_idx, e_wr);
          end else begin
            if (m_idx > 0 && e_b2b[m_idx-1])
              chk((m_since >= e_len[m_idx-1] - 1) && (m_since <= e_len[m_idx-1] + 1),
                  "R8 R5 frame length in ticks", m_since, e_len[m_idx-1]);
            m_act = 1'b1; m_t = 0; m_k = 0; m_data = 8'h00;
          end
          m_since = 0;
        end
      end else if (tick16) begin
        m_t++;
        if (m_t == 8 + 16 * m_k) begin
          if (m_k == 0) begin
            chk(txd == 1'b0, "R4 start bit", txd, 0);
          end else if (m_k <= e_n[m_idx]) begin
            m_data[m_k-1] = txd;
          end else if (e_par[m_idx] >= 0 && m_k == e_n[m_idx] + 1) begin
            m_par = txd;
          end else begin
            chk(txd == 1'b1, "R5 stop bit", txd, 1);
            chk(m_data == (e_data[m_idx] & 8'((1 << e_n[m_idx]) - 1)),
                "R4 data bits", m_data, e_data[m_idx]);
            if (e_par[m_idx] >= 0)
              chk(int'(m_par) == e_par[m_idx], "R6 parity bit", m_par, e_par[m_idx]);
            m_idx++;
            m_act = 1'b0;
          end
          m_k++;
        end
      end
    end
    m_prev = txd;
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "R8 watchdog expired", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_take();
    while (!hold_empty) @(negedge clk);
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    while (!shift_empty) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic set_fmt(input logic [1:0] wl, input bit s2, input bit pe,
                         input bit ev, input bit st);
    @(negedge clk);
    cfg_wlen = wl; cfg_stop2 = s2; cfg_par_en = pe;
    cfg_par_even = ev; cfg_par_stick = st;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", txd, 1);
    chk(hold_empty == 1'b1, "R1 reset hold_empty", hold_empty, 1);
    chk(shift_empty == 1'b1, "R1 reset shift_empty", shift_empty, 1);

    // directed first write: flag and start-bit timing
    set_fmt(2'b11, 0, 0, 0, 0);
    push(8'hA5, 0);
    wr_en = 1'b1; wr_data = 8'hA5;
    @(negedge clk);
    wr_en = 1'b0;
    chk(hold_empty == 1'b0, "R2 hold_empty after write", hold_empty, 0);
    chk(shift_empty == 1'b0, "R3 shift_empty after write", shift_empty, 0);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R2 hold_empty after move", hold_empty, 1);
    chk(shift_empty == 1'b0, "R3 shift_empty while sending", shift_empty, 0);
    @(negedge clk);
    chk(txd == 1'b0, "R4 start bit on line", txd, 0);
    wait_quiet();

    // parity modes, 7-bit data
    set_fmt(2'b10, 0, 1, 1, 0); push(8'h35, 0); write(8'h35); wait_quiet();
    set_fmt(2'b10, 0, 1, 0, 0); push(8'h35, 0); write(8'h35); wait_quiet();
    set_fmt(2'b10, 0, 1, 0, 1); push(8'h2A, 0); write(8'h2A); wait_quiet();
    set_fmt(2'b10, 0, 1, 1, 1); push(8'h7F, 0); write(8'h7F); wait_quiet();

    // long stop: 1.5 for 5-bit, 2 for 6-bit, measured back to back
    set_fmt(2'b00, 1, 0, 0, 0);
    push(8'h15, 1); push(8'h0A, 0);
    write(8'h15); wait_take(); write(8'h0A); wait_quiet();
    set_fmt(2'b01, 1, 1, 1, 0);
    push(8'h2C, 1); push(8'h13, 0);
    write(8'h2C); wait_take(); write(8'h13); wait_quiet();

    // R10: format change after load applies only to the next frame
    set_fmt(2'b11, 0, 0, 0, 0);
    push(8'hC3, 1);
    write(8'hC3); wait_take();
    set_fmt(2'b00, 1, 1, 1, 0);
    push(8'h13, 0);
    write(8'h13); wait_quiet();

    // R9: overwrite while full, only the last byte goes out
    set_fmt(2'b11, 0, 0, 0, 0);
    push(8'h11, 1);
    write(8'h11); wait_take();
    write(8'h22);
    write(8'h33);
    chk(hold_empty == 1'b0, "R9 holding stays full", hold_empty, 0);
    push(8'h33, 0);
    wait_quiet();
    chk(m_idx == e_wr, "R9 frames received", m_idx, e_wr);

    // R7: break while idle, flags unaffected
    mon_en = 1'b0;
    @(negedge clk); cfg_brk = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R7 break drives space", txd, 0);
    repeat (20) @(negedge clk);
    chk(txd == 1'b0, "R7 break held", txd, 0);
    chk(shift_empty == 1'b1, "R7 flags during break", shift_empty, 1);
    cfg_brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R7 release to mark", txd, 1);
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // random frames, some back to back
    for (int it = 0; it < 14; it++) begin
      logic [7:0] d1, d2;
      bit pair;
      d1 = 8'($urandom); d2 = 8'($urandom);
      pair = 1'($urandom);
      set_fmt(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      push(d1, pair);
      write(d1);
      if (pair) begin
        wait_take();
        push(d2, 0);
        write(d2);
      end
      wait_quiet();
    end

    chk(m_idx == e_wr, "R8 all frames received", m_idx, e_wr);
    chk(txd == 1'b1 && shift_empty == 1'b1, "R3 quiet at end", {txd, shift_empty}, 3);
    summary();
    $finish;
  end

endmodule